// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block turns the output of an infrared demodulator into a stream of run-length bytes. The raw line passes through a two-flop synchronizer. It is sampled once every `PRESCALE` clocks. With an 8 MHz clock and the default of 64, that gives one sample every 8 us. The sampled value can be inverted, and short glitches are removed by a programmable noise filter. The block then counts how many samples the filtered line stays at each level.

Each finished run becomes one byte. Bit 7 holds the level: 1 is active and 0 is idle. Bits 6:0 hold the run length in samples minus one. A run longer than 128 samples is split into several bytes. Each byte comes with a single-cycle write strobe for a downstream FIFO. When the line has been idle for longer than a programmed threshold, the block flushes the pending idle run, pulses a packet-end flag and then waits for the next active level.

Top module: `ir_run_encoder`

## Requirements
- R1: The synchronized input is sampled once every PRESCALE clocks. The sample counter restarts from zero each time the block is enabled, and run lengths are counted in samples.
- R2: Each emitted byte carries the run level in bit 7 (1 = active, 0 = idle) and the run length minus one in bits 6:0, so a field value of n stands for n+1 samples.
- R3: A run of more than 128 samples is emitted as bytes with field 127, one for each full 128 samples, followed by one byte holding the remainder. All of these bytes carry the same level bit.
- R4: When `invert` is 1, the synchronized input is complemented before filtering, so a raw low level is treated as active.
- R5: A level change is accepted only on the (noise_thr+1)-th consecutive sample that differs from the accepted level. A shorter excursion is absorbed into the surrounding run, and the lengths of accepted runs are preserved.
- R6: No bytes are emitted for idle samples until the first active level appears. An idle run that reaches max(idle_thr,1) samples ends the packet on its next idle sample. At that point `pkt_end` pulses together with a flush byte of level 0 that holds the pending idle samples, excluding the terminating sample. Idle samples after that are not encoded.
- R7: `wr_en` is high for exactly one clock for each byte. `pkt_end` is high for exactly one clock, and only in a cycle where `wr_en` carries an idle-level byte.
- R8: While `glb_en` or `rx_en` is low, no bytes and no packet-end pulse are produced. All run state is cleared, so a run in progress when the block is disabled is discarded.
- R9: After reset, `wr_en` and `pkt_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| invert | input | 1 | Complement the sampled input |
| noise_thr | input | NOISE_W | Extra samples a level change must persist |
| idle_thr | input | IDLE_W | Idle samples before a packet ends |
| ir_raw | input | 1 | Asynchronous demodulator output |
| wr_en | output | 1 | One-cycle write strobe for each byte |
| wr_data | output | LEN_W+1 | Level bit and length-minus-one field |
| pkt_end | output | 1 | One-cycle packet-end pulse |

## Verification
The bench builds the encoder with PRESCALE=4, so each sample lasts four clocks. This brings runs of 300 samples, which need two full chunks and a remainder, within a few thousand cycles. It also makes an idle threshold of 150 reachable, so an idle run is chunked before its flush. The default 7-bit length field and 6-bit and 8-bit thresholds are kept. This lets the bench reach field values 0 and 127 and switch the noise threshold between 0 and 1.

// File: rtl/ir_run_encoder.sv
module ir_run_encoder #(
  parameter int PRESCALE = 64,
  parameter int NOISE_W  = 6,
  parameter int IDLE_W   = 8,
  parameter int LEN_W    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic               rx_en,
  input  logic               invert,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  input  logic               ir_raw,
  output logic               wr_en,
  output logic [LEN_W:0]     wr_data,
  output logic               pkt_end
);
  localparam int PC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PC_W-1:0]  PC_LAST = PC_W'(PRESCALE - 1);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic              sync1, sync2;
  logic [PC_W-1:0]   pcnt;
  logic              flt, cur, in_pkt;
  logic [NOISE_W-1:0] ncnt;
  logic [LEN_W-1:0]  len;
  logic [IDLE_W-1:0] idl;

  wire active  = glb_en & rx_en;
  wire tick    = active && (pcnt == PC_LAST);
  wire smp     = sync2 ^ invert;
  wire differ  = smp != flt;
  wire accept  = differ && (ncnt >= noise_thr);
  wire lvl     = accept ? smp : flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= ir_raw;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; flt <= 1'b0; ncnt <= '0; cur <= 1'b0; in_pkt <= 1'b0;
      len <= '0; idl <= '0; wr_en <= 1'b0; wr_data <= '0; pkt_end <= 1'b0;
    end else if (!active) begin
      pcnt <= '0; flt <= 1'b0; ncnt <= '0; cur <= 1'b0; in_pkt <= 1'b0;
      len <= '0; idl <= '0; wr_en <= 1'b0; pkt_end <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      pkt_end <= 1'b0;
      pcnt    <= tick ? '0 : pcnt + 1'b1;
      if (tick) begin
        flt  <= lvl;
        ncnt <= (differ && !accept) ? ncnt + 1'b1 : '0;
        if (!in_pkt) begin
          if (lvl) begin
            in_pkt <= 1'b1;
            cur    <= 1'b1;
            len    <= '0;
          end
        end else if (lvl != cur) begin
          wr_en   <= 1'b1;
          wr_data <= {cur, len};
          cur     <= lvl;
          len     <= '0;
          idl     <= IDLE_W'(1);
        end else if (!cur && idl >= idle_thr) begin
          wr_en   <= 1'b1;
          wr_data <= {1'b0, len};
          pkt_end <= 1'b1;
          in_pkt  <= 1'b0;
        end else begin
          if (len == LEN_MAX) begin
            wr_en   <= 1'b1;
            wr_data <= {cur, len};
            len     <= '0;
          end else begin
            len <= len + 1'b1;
          end
          if (!cur) idl <= idl + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ir_run_encoder_chk.sv
module ir_run_encoder_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          glb_en,
  input logic          rx_en,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          pkt_end
);
  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_pkt_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !pkt_end);
  p_flush_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> (wr_en && !wr_data[DW-1]));
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(glb_en && rx_en) |=> (!wr_en && !pkt_end));
endmodule

bind ir_run_encoder ir_run_encoder_chk #(.DW(LEN_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rx_en(rx_en),
  .wr_en(wr_en), .wr_data(wr_data), .pkt_end(pkt_end)
);

// File: tb/tb_ir_run_encoder.sv
module tb_ir_run_encoder;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b0, rx_en = 1'b0, invert = 1'b0, ir_raw = 1'b0;
  logic [5:0] noise_thr = 6'd1;
  logic [7:0] idle_thr = 8'd20;
  logic wr_en, pkt_end;
  logic [7:0] wr_data;

  int checks = 0;
  int errors = 0;
  logic [8:0] expq[$];
  string tag = "R1";

  always #2.5 clk = ~clk;

  ir_run_encoder #(.PRESCALE(P)) dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rx_en(rx_en), .invert(invert),
    .noise_thr(noise_thr), .idle_thr(idle_thr), .ir_raw(ir_raw),
    .wr_en(wr_en), .wr_data(wr_data), .pkt_end(pkt_end)
  );

  task automatic drive(input logic lvl, input int n);
    ir_raw = lvl;
    repeat (n * P) @(negedge clk);
  endtask

  task automatic exp_byte(input logic lvl, input int field);
    expq.push_back({1'b0, lvl, field[6:0]});
  endtask

  task automatic exp_pkt();
    expq.push_back(9'h100);
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pop and compare as the design produces results
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (expq.size() == 0) check(0, "unexpected byte", int'(wr_data), -1);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        check(e == {1'b0, wr_data}, "byte", int'(wr_data), int'(e));
      end
    end
    if (rst_n && pkt_end) begin
      if (expq.size() == 0) check(0, "unexpected pkt_end", 1, 0);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        check(e == 9'h100, "pkt_end", 9'h100, int'(e));
      end
    end
  end

  task automatic drain(input string t);
    repeat (4 * P) @(negedge clk);
    tag = t;
    check(expq.size() == 0, "missing outputs", expq.size(), 0);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R9";
    check(wr_en == 1'b0, "reset wr_en", wr_en, 0);
    check(pkt_end == 1'b0, "reset pkt_end", pkt_end, 0);
    rst_n = 1'b1;
    @(negedge clk);
    glb_en = 1'b1; rx_en = 1'b1;

    // R1 R2 R6: basic packet, leading idle discarded
    tag = "R2";
    exp_byte(1, 9); exp_byte(0, 5); exp_byte(1, 2); exp_byte(0, 19); exp_pkt();
    drive(0, 5); drive(1, 10); drive(0, 6); drive(1, 3); drive(0, 30);
    drain("R1");

    // R5: one-sample idle glitch absorbed into an active run
    tag = "R5";
    exp_byte(1, 20); exp_byte(0, 19); exp_pkt();
    drive(1, 10); drive(0, 1); drive(1, 10); drive(0, 25);
    drain("R5");

    // R5: two-sample excursion accepted
    exp_byte(1, 4); exp_byte(0, 1); exp_byte(1, 4); exp_byte(0, 19); exp_pkt();
    drive(1, 5); drive(0, 2); drive(1, 5); drive(0, 25);
    drain("R5");

    // R5: lone active sample outside a packet is rejected
    drive(1, 1); drive(0, 25);
    drain("R5");

    // R5 R2: threshold 0 accepts a one-sample pulse, field 0
    noise_thr = 6'd0;
    tag = "R5";
    exp_byte(1, 0); exp_byte(0, 19); exp_pkt();
    drive(1, 1); drive(0, 25);
    drain("R2");
    noise_thr = 6'd1;

    // R3: long active run split
    tag = "R3";
    exp_byte(1, 127); exp_byte(1, 127); exp_byte(1, 43); exp_byte(0, 19); exp_pkt();
    drive(1, 300); drive(0, 25);
    drain("R3");

    // R6 R3: idle threshold 150, idle run chunked before flush
    idle_thr = 8'd150;
    tag = "R6";
    exp_byte(1, 3); exp_byte(0, 127); exp_byte(0, 21); exp_pkt();
    drive(1, 4); drive(0, 160);
    drain("R6");
    idle_thr = 8'd20;

    // R4: inverted input
    tag = "R4";
    invert = 1'b1;
    exp_byte(1, 5); exp_byte(0, 19); exp_pkt();
    drive(1, 3); drive(0, 6); drive(1, 25);
    drain("R4");
    invert = 1'b0; ir_raw = 1'b0;
    drive(0, 3);

    // R8: rx_en low, pulses ignored
    tag = "R8";
    rx_en = 1'b0;
    drive(1, 10); drive(0, 5);
    drain("R8");
    // R8: glb_en low, pulses ignored
    rx_en = 1'b1; glb_en = 1'b0;
    drive(1, 10); drive(0, 5);
    drain("R8");
    // R8: run in progress discarded on disable
    glb_en = 1'b1;
    drive(1, 10);
    rx_en = 1'b0;
    drive(0, 5);
    drain("R8");
    // R8 R1: resumes cleanly after re-enable
    rx_en = 1'b1;
    exp_byte(1, 7); exp_byte(0, 19); exp_pkt();
    drive(0, 5); drive(1, 8); drive(0, 25);
    drain("R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule